// File: doc/BRIEF.md
# Packed Right-Shift Unit

The block shifts a 64-bit packed operand right by one count that applies to every lane. It handles logical shifts on 16-bit, 32-bit and 64-bit lanes and an arithmetic shift on 16-bit lanes. Its input is the second opcode byte of an already-fetched instruction, the mod and reg fields of the ModRM byte, the source operand, and a count. The count is either a full 64-bit second operand or a zero-extended 8-bit immediate. Operand fetch from registers or memory happens before this block.

Each accepted operation gives a registered result one cycle later, and the block takes a new operation every cycle. If the opcode combination is not recognised, the block raises a one-cycle invalid flag and keeps its previous result. The decode, execute and retire stages downstream read `res_o` only when `res_valid_o` is high.

Top module: `pshift_unit`

## Requirements
- R1: While rst_ni is low and after it is released, res_o is all zeros and res_valid_o and inv_op_o are low until the first operation.
- R2: Opcode byte 0xD1 shifts each 16-bit lane logically right, 0xD2 each 32-bit lane, and 0xD3 the whole 64-bit word. The count comes from cnt_op_i and vacated bits fill with zeros.
- R3: Opcode byte 0xE1 shifts each 16-bit lane arithmetically right by cnt_op_i, and vacated bits fill with that lane's sign bit (bit 15 of the lane).
- R4: Opcode bytes 0x71, 0x72 and 0x73 with mod = 2'b11 and reg = 3'b010 are logical right shifts on 16-, 32- and 64-bit lanes by imm_i zero-extended. 0x71 with reg = 3'b100 is an arithmetic 16-bit shift by imm_i.
- R5: The count is unsigned and 64 bits wide. For a logical shift, a count equal to or above the lane width gives an all-zero lane.
- R6: For an arithmetic shift, a count of 16 or more sets every bit of each lane to that lane's sign bit.
- R7: When a valid operation is presented at a clock edge, res_o holds its result and res_valid_o is high after that same edge. Back-to-back operations each give a result on consecutive cycles.
- R8: These cases are invalid: any other opcode byte; an immediate-group opcode with mod other than 2'b11; reg other than 3'b010 or 3'b100; reg 3'b100 with 0x72 or 0x73. An invalid case sets inv_op_o for one cycle with res_valid_o low and res_o unchanged.
- R9: A cycle with valid_i low leaves res_valid_o and inv_op_o low on the next cycle and leaves res_o unchanged.
- R10: For the register-count opcodes 0xD1, 0xD2, 0xD3 and 0xE1, the mod and reg inputs and imm_i have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| opc_i | input | 8 | Opcode byte following the 0x0F escape |
| modrm_mod_i | input | 2 | ModRM mod field |
| modrm_reg_i | input | 3 | ModRM reg field |
| src_i | input | 64 | Packed operand to shift |
| cnt_op_i | input | 64 | Count for register-count forms |
| imm_i | input | 8 | Count for immediate forms |
| res_o | output | 64 | Registered shift result |
| res_valid_o | output | 1 | res_o updated by the previous operation |
| inv_op_o | output | 1 | Previous operation was not recognised |

## Verification
The only state is the result register and two flags, so any fault shows at the ports one cycle after the operation that exposes it. A bad decode shows as the wrong flag, or as a result with the wrong lane width or the wrong fill. A hold fault shows as res_o changing after an invalid or idle cycle. Sweeping counts across each lane-width boundary separates an error in the in-range shift path from an error in the out-of-range saturation path.

// File: rtl/pshift_pkg.sv
`timescale 1ns/1ps
package pshift_pkg;
  localparam logic [7:0] OPC_SRL16 = 8'hD1;
  localparam logic [7:0] OPC_SRL32 = 8'hD2;
  localparam logic [7:0] OPC_SRL64 = 8'hD3;
  localparam logic [7:0] OPC_SRA16 = 8'hE1;
  localparam logic [7:0] OPC_GRP16 = 8'h71;
  localparam logic [7:0] OPC_GRP32 = 8'h72;
  localparam logic [7:0] OPC_GRP64 = 8'h73;
  localparam logic [2:0] REG_LOG   = 3'b010;
  localparam logic [2:0] REG_ARI   = 3'b100;
  localparam logic [1:0] MOD_REG   = 2'b11;

  localparam int NUM_LW = 3;

  typedef enum logic [1:0] {LW_16 = 2'd0, LW_32 = 2'd1, LW_64 = 2'd2} lane_w_e;

  typedef struct packed {
    logic    ok;
    lane_w_e lw;
    logic    arith;
    logic    use_imm;
  } shop_t;
endpackage

// File: rtl/pshift_decode.sv
`timescale 1ns/1ps
module pshift_decode
  import pshift_pkg::*;
(
  input  logic [7:0] opc_i,
  input  logic [1:0] mod_i,
  input  logic [2:0] reg_i,
  output shop_t      op_o
);
  always_comb begin
    op_o         = '0;
    op_o.lw      = LW_16;
    unique case (opc_i)
      OPC_SRL16: op_o.ok = 1'b1;
      OPC_SRL32: begin op_o.ok = 1'b1; op_o.lw = LW_32; end
      OPC_SRL64: begin op_o.ok = 1'b1; op_o.lw = LW_64; end
      OPC_SRA16: begin op_o.ok = 1'b1; op_o.arith = 1'b1; end
      OPC_GRP16, OPC_GRP32, OPC_GRP64: begin
        op_o.use_imm = 1'b1;
        op_o.lw = (opc_i == OPC_GRP16) ? LW_16 :
                  (opc_i == OPC_GRP32) ? LW_32 : LW_64;
        if (mod_i == MOD_REG) begin
          if (reg_i == REG_LOG) op_o.ok = 1'b1;
          else if (reg_i == REG_ARI && opc_i == OPC_GRP16) begin
            op_o.ok    = 1'b1;
            op_o.arith = 1'b1;
          end
        end
      end
      default: op_o.ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/pshift_lane.sv
`timescale 1ns/1ps
module pshift_lane #(
  parameter int LANE_W = 16,
  parameter int CNT_W  = 64
) (
  input  logic [LANE_W-1:0] a_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              arith_i,
  output logic [LANE_W-1:0] y_o
);
  localparam int SH_W = $clog2(LANE_W);

  logic              over;
  logic [SH_W-1:0]   amt;
  logic              fill;

  assign over = |cnt_i[CNT_W-1:SH_W];
  assign amt  = cnt_i[SH_W-1:0];
  assign fill = arith_i & a_i[LANE_W-1];

  always_comb begin
    if (over)         y_o = {LANE_W{fill}};
    else if (arith_i) y_o = LANE_W'($signed(a_i) >>> amt);
    else              y_o = a_i >> amt;
  end
endmodule

// File: rtl/pshift_array.sv
`timescale 1ns/1ps
module pshift_array #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              arith_i,
  output logic [DATA_W-1:0] y_o
);
  localparam int NUM_LANES = DATA_W / LANE_W;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    pshift_lane #(.LANE_W(LANE_W), .CNT_W(DATA_W)) u_lane (
      .a_i    (a_i[l*LANE_W +: LANE_W]),
      .cnt_i  (cnt_i),
      .arith_i(arith_i),
      .y_o    (y_o[l*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/pshift_unit.sv
`timescale 1ns/1ps
module pshift_unit
  import pshift_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [7:0]        opc_i,
  input  logic [1:0]        modrm_mod_i,
  input  logic [2:0]        modrm_reg_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] cnt_op_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] res_o,
  output logic              res_valid_o,
  output logic              inv_op_o
);
  shop_t             dec;
  logic [DATA_W-1:0] cnt;
  logic [DATA_W-1:0] y_lw [NUM_LW];
  logic [DATA_W-1:0] y_sel;

  pshift_decode u_dec (
    .opc_i(opc_i),
    .mod_i(modrm_mod_i),
    .reg_i(modrm_reg_i),
    .op_o (dec)
  );

  assign cnt = dec.use_imm ? DATA_W'(imm_i) : cnt_op_i;

  for (genvar g = 0; g < NUM_LW; g++) begin : g_lw
    pshift_array #(.DATA_W(DATA_W), .LANE_W(16 << g)) u_arr (
      .a_i    (src_i),
      .cnt_i  (cnt),
      .arith_i(dec.arith),
      .y_o    (y_lw[g])
    );
  end

  always_comb begin
    unique case (dec.lw)
      LW_32:   y_sel = y_lw[1];
      LW_64:   y_sel = y_lw[2];
      default: y_sel = y_lw[0];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o       <= '0;
      res_valid_o <= 1'b0;
      inv_op_o    <= 1'b0;
    end else begin
      res_valid_o <= valid_i & dec.ok;
      inv_op_o    <= valid_i & ~dec.ok;
      if (valid_i && dec.ok) res_o <= y_sel;
    end
  end
endmodule

// File: rtl/pshift_checks.sv
`timescale 1ns/1ps
module pshift_checks #(
  parameter int DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [7:0]        opc_i,
  input logic [DATA_W-1:0] src_i,
  input logic [DATA_W-1:0] cnt_op_i,
  input logic [DATA_W-1:0] res_o,
  input logic              res_valid_o,
  input logic              inv_op_o
);
  assert_flags_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(res_valid_o && inv_op_o));

  assert_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o || inv_op_o) |-> $past(valid_i));

  assert_hold_invalid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_op_o |-> res_o == $past(res_o));

  assert_hold_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> $stable(res_o));

  assert_srl64_sat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opc_i == 8'hD3 && |cnt_op_i[DATA_W-1:6]) |=> res_o == '0);

  for (genvar k = 0; k < DATA_W/16; k++) begin : g_sra
    assert_sra_sat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && opc_i == 8'hE1 && |cnt_op_i[DATA_W-1:4]) |=>
      res_o[k*16 +: 16] == {16{$past(src_i[k*16+15])}});
  end
endmodule

bind pshift_unit pshift_checks #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .opc_i      (opc_i),
  .src_i      (src_i),
  .cnt_op_i   (cnt_op_i),
  .res_o      (res_o),
  .res_valid_o(res_valid_o),
  .inv_op_o   (inv_op_o)
);

// File: tb/sim_pshift_unit.sv
`timescale 1ns/1ps
module sim_pshift_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  opc_i = '0;
  logic [1:0]  modrm_mod_i = '0;
  logic [2:0]  modrm_reg_i = '0;
  logic [63:0] src_i = '0;
  logic [63:0] cnt_op_i = '0;
  logic [7:0]  imm_i = '0;
  logic [63:0] res_o;
  logic        res_valid_o;
  logic        inv_op_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic [63:0] last_res = '0;

  always #10 clk_i = ~clk_i;

  pshift_unit u0 (.*);

  function automatic logic [63:0] model(logic [63:0] a, logic [63:0] c, int w, bit ar);
    logic [63:0] r = '0;
    for (int base = 0; base < 64; base += w)
      for (int i = 0; i < w; i++)
        if (c < 64'(w - i)) r[base+i] = a[base + i + int'(c)];
        else                r[base+i] = ar ? a[base+w-1] : 1'b0;
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(logic [7:0] opc, logic [1:0] md, logic [2:0] rg,
                     logic [63:0] a, logic [63:0] c, logic [7:0] imm,
                     bit exp_ok, logic [63:0] exp, string req);
    valid_i = 1'b1; opc_i = opc; modrm_mod_i = md; modrm_reg_i = rg;
    src_i = a; cnt_op_i = c; imm_i = imm;
    @(negedge clk_i);
    if (exp_ok) begin
      chk(res_valid_o && !inv_op_o, {req, " flags"}, {62'd0, res_valid_o, inv_op_o}, 64'd2);
      chk(res_o === exp, req, res_o, exp);
      last_res = exp;
    end else begin
      chk(inv_op_o && !res_valid_o, {req, " flags"}, {62'd0, res_valid_o, inv_op_o}, 64'd1);
      chk(res_o === last_res, {req, " hold"}, res_o, last_res);
    end
  endtask

  logic [63:0] pats [4] = '{64'hF0E1_D2C3_B4A5_9687, 64'h7FFF_8000_0001_FFFE,
                            64'h8000_0000_0000_0001, 64'h0123_4567_89AB_CDEF};
  logic [63:0] bigs [4] = '{64'h0000_0000_0001_0000, 64'h0000_0001_0000_0000,
                            64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF};
  logic [7:0]  ropc [4] = '{8'hD1, 8'hD2, 8'hD3, 8'hE1};
  int          rw   [4] = '{16, 32, 64, 16};

  initial begin
    repeat (3) @(negedge clk_i);
    chk(res_o === '0 && !res_valid_o && !inv_op_o, "R1 in reset", res_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(res_o === '0 && !res_valid_o && !inv_op_o, "R1 after release", res_o, '0);

    // R2 R3 R5 R6 R7: register-count forms, back to back, counts across boundaries
    for (int p = 0; p < 4; p++)
      for (int v = 0; v < 4; v++) begin
        for (int c = 0; c <= 70; c++)
          run(ropc[v], 2'b11, 3'b000, pats[p], 64'(c), 8'hFF, 1'b1,
              model(pats[p], 64'(c), rw[v], v == 3),
              (v == 3) ? ((c >= 16) ? "R6 sra sat" : "R3 sra") :
              ((c >= rw[v]) ? "R5 srl sat" : "R2 srl"));
        for (int b = 0; b < 4; b++)
          run(ropc[v], 2'b11, 3'b000, pats[p], bigs[b], 8'h01, 1'b1,
              model(pats[p], bigs[b], rw[v], v == 3),
              (v == 3) ? "R6 sra big count" : "R5 srl big count");
      end

    // R4: immediate group, every immediate value
    for (int p = 0; p < 4; p++)
      for (int v = 0; v < 4; v++)
        for (int im = 0; im < 256; im++)
          run((v == 3) ? 8'h71 : 8'(8'h71 + v), 2'b11, (v == 3) ? 3'b100 : 3'b010,
              pats[p], 64'hFFFF_FFFF_FFFF_FFFF, 8'(im), 1'b1,
              model(pats[p], 64'(im), rw[v], v == 3), "R4 imm");

    // R10: register forms ignore mod/reg/imm
    run(8'hD1, 2'b00, 3'b111, pats[0], 64'd3, 8'h00, 1'b1, model(pats[0], 64'd3, 16, 0), "R10 D1");
    run(8'hE1, 2'b01, 3'b010, pats[1], 64'd5, 8'h20, 1'b1, model(pats[1], 64'd5, 16, 1), "R10 E1");
    run(8'hD3, 2'b10, 3'b100, pats[3], 64'd9, 8'h02, 1'b1, model(pats[3], 64'd9, 64, 0), "R10 D3");

    // R8: invalid combinations
    run(8'hD4, 2'b11, 3'b010, pats[2], 64'd1, 8'd1, 1'b0, '0, "R8 bad opcode");
    run(8'h71, 2'b10, 3'b010, pats[2], 64'd1, 8'd1, 1'b0, '0, "R8 mod not 11");
    run(8'h72, 2'b11, 3'b100, pats[2], 64'd1, 8'd1, 1'b0, '0, "R8 sra dword");
    run(8'h73, 2'b11, 3'b100, pats[2], 64'd1, 8'd1, 1'b0, '0, "R8 sra qword");
    run(8'h71, 2'b11, 3'b110, pats[2], 64'd1, 8'd1, 1'b0, '0, "R8 reg 110");
    run(8'h72, 2'b11, 3'b000, pats[2], 64'd1, 8'd1, 1'b0, '0, "R8 reg 000");
    run(8'hE2, 2'b11, 3'b100, pats[2], 64'd1, 8'd1, 1'b0, '0, "R8 E2");
    run(8'h71, 2'b11, 3'b010, pats[1], 64'd0, 8'd4, 1'b1, model(pats[1], 64'd4, 16, 0), "R8 recover");

    // R9: idle cycles with junk on the inputs
    valid_i = 1'b0; opc_i = 8'hD3; src_i = pats[0]; cnt_op_i = 64'd1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk(!res_valid_o && !inv_op_o, "R9 idle flags", {62'd0, res_valid_o, inv_op_o}, '0);
      chk(res_o === last_res, "R9 idle hold", res_o, last_res);
    end

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule